// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

This block keeps a free-running 32-bit count of elapsed periods, where one period is a programmable number of cycles of the slow clock that drives it. A 16-bit divider sets the period length. A software-visible alarm value is compared with the count on every step. Two sticky event flags record an alarm hit and a count step. Each flag can raise a single interrupt line through its own enable.

Software uses four word registers on a simple synchronous bus: control, alarm, count (read-only) and events. A control write with the restart bit set zeroes the count and the divider phase in the same cycle, and loads the new divider value. An alarm value of all ones parks the alarm so that it never fires. Reading the event register clears it. Because the count is one register updated on one clock edge, two back-to-back reads give the same value unless a step falls between them.

Top module: `sec_timer`

## Requirements
- R1: After reset the control register reads 0x00008000, the alarm register reads 0xFFFFFFFF, the count reads 0, the event register reads 0 and irq is low.
- R2: Control register at offset 0x0: bits 15:0 divider value, bit 16 alarm interrupt enable, bit 17 step interrupt enable, bit 18 restart command; bit 18 and bits 31:19 always read 0.
- R3: With divider value P (0 means 65536), the count steps by one every P clock cycles, and the first step comes P cycles after the edge that takes a restart write.
- R4: A control write with bit 18 set zeroes the count and the divider phase on that edge; a control write with bit 18 clear leaves the count and phase running.
- R5: Event bit 0 is set on the step at which the count becomes equal to the alarm register (offset 0x4, read/write); an alarm value of 0xFFFFFFFF never sets it.
- R6: Event bit 1 is set on every step of the count.
- R7: A read of the event register (offset 0xC) clears both event bits on that edge; an event arriving on the same edge stays set.
- R8: irq is high exactly when event bit n and control bit 16+n are both set, for n = 0 or 1.
- R9: The count register at offset 0x8 is read-only; writes to offsets 0x8 and 0xC change nothing, and back-to-back count reads with no step between them return equal values.
- R10: rdata shows the addressed register in the cycle rd_en is high and is 0 otherwise; an address with bits 1:0 not zero reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| irq | output | 1 | Interrupt, level high |

## Verification
The bench models the count and both event bits from the number of clock edges since the last restart and since the last event read. It then goes after the corners where a faulty design drifts. A read that clears the events on the same edge as a step must keep the step flag; a design where clear wins loses an interrupt. A divider value of 0 must give 65536 cycles per step; a design that takes it as 0 or 1 would step at once. A control write without restart must not reset the phase, or the count falls behind. Writes to the count, to the events or to a misaligned address must leave the model intact, or the count and event reads diverge from the prediction.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_ALARM = 2'd1,
    SEL_VALUE = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;

  localparam int STAT_W   = 2;
  localparam int ST_ALARM = 0;
  localparam int ST_INCR  = 1;

  // Number of slow-clock cycles per count step for a divider value.
  function automatic int unsigned wrap_period(input int unsigned presc_val,
                                              input int unsigned pre_w);
    return (presc_val == 0) ? (32'd1 << pre_w) : presc_val;
  endfunction

endpackage

// File: rtl/sec_timer_prescale.sv
module sec_timer_prescale
  import sec_timer_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);

  localparam int PC_W = PRE_W + 1;

  logic [PC_W-1:0] pre_q;
  logic [PC_W-1:0] pre_inc;
  logic [PC_W-1:0] period;

  always_comb begin
    period  = PC_W'(wrap_period(32'(presc), PRE_W));
    pre_inc = pre_q + 1'b1;
    tick    = !restart && (pre_inc >= period);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else if (restart || tick)
      pre_q <= '0;
    else
      pre_q <= pre_inc;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period > 1) |=> (!tick || presc == PRE_W'(1)));

  // R4
  restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!tick || presc == PRE_W'(1)));

endmodule

// File: rtl/sec_timer_count.sv
module sec_timer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] count,
  output logic             alarm_hit
);

  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    cnt_next  = count + 1'b1;
    alarm_hit = tick && (cnt_next == alarm) && (alarm != '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (restart)
      count <= '0;
    else if (tick)
      count <= cnt_next;
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + 1'b1);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(count));

  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == '0);

  // R5
  alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> (count == $past(alarm) && count != '1));

endmodule

// File: rtl/sec_timer_regs.sv
module sec_timer_regs
  import sec_timer_pkg::*;
#(
  parameter int PRE_W  = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              tick,
  input  logic              alarm_hit,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic [PRE_W-1:0]  presc,
  output logic [CNT_W-1:0]  alarm,
  output logic              restart
);

  localparam int               RST_BIT   = PRE_W + 2;
  localparam logic [PRE_W-1:0] PRESC_RST = PRE_W'(1) << (PRE_W - 1);

  logic              word_hit;
  reg_sel_e          sel;
  logic              wr_mode;
  logic              wr_alarm;
  logic              stat_clr;
  logic [STAT_W-1:0] stat_set;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] en_q;
  logic [PRE_W-1:0]  presc_q;
  logic [CNT_W-1:0]  alarm_q;
  logic [CNT_W-1:0]  mode_word;
  logic [CNT_W-1:0]  rd_mux;

  always_comb begin
    word_hit = (addr[1:0] == 2'b00) && ((addr >> 4) == '0);
    sel      = reg_sel_e'(addr[3:2]);
    wr_mode  = wr_en && word_hit && (sel == SEL_MODE);
    wr_alarm = wr_en && word_hit && (sel == SEL_ALARM);
    restart  = wr_mode && wdata[RST_BIT];
    stat_clr = rd_en && word_hit && (sel == SEL_STAT);
    stat_set           = '0;
    stat_set[ST_ALARM] = alarm_hit;
    stat_set[ST_INCR]  = tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= PRESC_RST;
      en_q    <= '0;
      alarm_q <= '1;
      stat_q  <= '0;
    end else begin
      if (wr_mode) begin
        presc_q <= wdata[PRE_W-1:0];
        en_q    <= wdata[PRE_W +: STAT_W];
      end
      if (wr_alarm)
        alarm_q <= wdata;
      stat_q <= stat_set | (stat_q & ~{STAT_W{stat_clr}});
    end
  end

  always_comb begin
    mode_word                  = '0;
    mode_word[PRE_W-1:0]       = presc_q;
    mode_word[PRE_W +: STAT_W] = en_q;
    case (sel)
      SEL_MODE:  rd_mux = mode_word;
      SEL_ALARM: rd_mux = alarm_q;
      SEL_VALUE: rd_mux = count;
      SEL_STAT:  rd_mux = CNT_W'(stat_q);
      default:   rd_mux = '0;
    endcase
    rdata = (rd_en && word_hit) ? rd_mux : '0;
    irq   = |(stat_q & en_q);
    presc = presc_q;
    alarm = alarm_q;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && tick) |=> stat_q[ST_INCR]);

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !tick && !alarm_hit) |=> stat_q == '0);

  // R6
  incr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_INCR]) |-> $past(tick));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick || alarm_hit || wr_mode));

  // R2
  restart_rd0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> !mode_word[RST_BIT]);

endmodule

// File: rtl/sec_timer.sv
module sec_timer #(
  parameter int PRE_W  = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);

  logic             tick;
  logic             alarm_hit;
  logic             restart;
  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] alarm;
  logic [CNT_W-1:0] count;

  sec_timer_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .count     (count),
    .tick      (tick),
    .alarm_hit (alarm_hit),
    .rdata     (rdata),
    .irq       (irq),
    .presc     (presc),
    .alarm     (alarm),
    .restart   (restart)
  );

  sec_timer_prescale #(.PRE_W(PRE_W)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .presc   (presc),
    .tick    (tick)
  );

  sec_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .tick      (tick),
    .alarm     (alarm),
    .count     (count),
    .alarm_hit (alarm_hit)
  );

endmodule

// File: tb/sec_timer_tb.sv
module sec_timer_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench model state
  longint      e;          // edges since restart (or reset)
  longint      per;        // cycles per step
  longint      clr;        // edge count at the last event read
  logic [31:0] cur_alarm;
  logic [1:0]  cur_en;

  // Scoreboard queues
  logic [31:0] q_exp[$];
  logic [31:0] q_mask[$];
  string       q_tag[$];

  sec_timer u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [1:0] model_ev();
    logic [1:0] v;
    longint ap;
    ap   = longint'(cur_alarm) * per;
    v[1] = (e / per) > (clr / per);
    v[0] = (cur_alarm != 32'hFFFF_FFFF) && (cur_alarm != 0) && (ap > clr) && (ap <= e);
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      e++;
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    e++;
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 4'h0 && d[18]) begin
      e   = 0;
      per = (d[15:0] == 0) ? 65536 : longint'(d[15:0]);
    end else begin
      e++;
    end
    if (a == 4'h0) cur_en = d[17:16];
    if (a == 4'h4) cur_alarm = d;
  endtask

  // kind: 0 fixed value, 1 count model, 2 event model, 3 event masked
  task automatic bus_rd(input logic [3:0] a, input int kind,
                        input logic [31:0] fixed, input string tag);
    logic [31:0] ex;
    logic [31:0] mk;
    @(negedge clk);
    e++;
    rd_en = 1; addr = a;
    mk = 32'hFFFF_FFFF;
    case (kind)
      1:       ex = 32'(e / per);
      2:       ex = {30'd0, model_ev()};
      3:       begin ex = 0; mk = 0; end
      default: ex = fixed;
    endcase
    q_exp.push_back(ex); q_mask.push_back(mk); q_tag.push_back(tag);
    if (a == 4'hC) clr = e;
    @(negedge clk);
    rd_en = 0;
    e++;
  endtask

  task automatic chk_irq(input string tag);
    chk({31'd0, irq}, {31'd0, |(model_ev() & cur_en)}, tag);
  endtask

  // Monitor: samples between the driving negedge and the next posedge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rd_en) begin
        if (q_exp.size() == 0) begin
          checks++; errors++;
          $display("FAIL monitor read with no expectation actual=%h expected=none", rdata);
        end else begin
          logic [31:0] ex, mk;
          string tg;
          ex = q_exp.pop_front(); mk = q_mask.pop_front(); tg = q_tag.pop_front();
          if (mk != 0) chk(rdata & mk, ex & mk, tg);
        end
      end else if (rdata !== 32'd0) begin
        chk(rdata, 32'd0, "R10 rdata idle");
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    cur_alarm = 32'hFFFF_FFFF; cur_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    e = 0; per = 32768; clr = 0;

    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq after reset");
    bus_rd(4'h0, 0, 32'h0000_8000, "R1 control reset");
    bus_rd(4'h4, 0, 32'hFFFF_FFFF, "R1 alarm reset");
    bus_rd(4'h8, 1, 0, "R1 count reset");
    bus_rd(4'hC, 2, 0, "R1 events reset");

    // R5 alarm register read/write
    bus_wr(4'h4, 32'd3);
    bus_rd(4'h4, 0, 32'd3, "R5 alarm readback");

    // R4 restart with divider 4, R2 layout
    bus_wr(4'h0, 32'h0004_0004);
    bus_rd(4'hC, 3, 0, "R7 clear after restart");
    bus_rd(4'h0, 0, 32'h0000_0004, "R2 restart reads 0");
    bus_rd(4'h8, 1, 0, "R3 count after restart");
    bus_rd(4'h8, 1, 0, "R9 back-to-back count");
    idle(3);
    bus_rd(4'h8, 1, 0, "R3 count step P=4");
    bus_rd(4'hC, 2, 0, "R6 step flag");
    chk_irq("R8 irq masked");

    // R4 control write without restart keeps counting; enables on
    bus_wr(4'h0, 32'h0003_0004);
    bus_rd(4'h0, 0, 32'h0003_0004, "R2 enable bits");
    bus_rd(4'h8, 1, 0, "R4 no restart keeps count");
    chk_irq("R8 irq before alarm");
    idle(4);
    chk_irq("R8 irq with events");
    bus_rd(4'hC, 2, 0, "R5 alarm flag");
    chk_irq("R8 irq after clear");

    // R7 set wins over read clear
    while (((e + 2) % per) != 0) idle(1);
    bus_rd(4'hC, 2, 0, "R7 clear on step edge");
    bus_rd(4'hC, 2, 0, "R7 set wins");

    // R9 writes to count/events ignored; R10 misaligned access
    bus_wr(4'h8, 32'h0000_0055);
    bus_wr(4'hC, 32'h0000_0000);
    bus_rd(4'h8, 1, 0, "R9 count write ignored");
    bus_rd(4'hC, 2, 0, "R9 event write ignored");
    bus_wr(4'h1, 32'h0004_0009);
    bus_rd(4'h8, 1, 0, "R10 misaligned write ignored");
    bus_rd(4'h2, 0, 32'd0, "R10 misaligned read zero");
    bus_rd(4'h0, 0, 32'h0003_0004, "R10 control unchanged");

    // R5 all-ones alarm never fires
    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_wr(4'h0, 32'h0004_0002);
    bus_rd(4'hC, 3, 0, "R7 clear after restart");
    idle(20);
    bus_rd(4'h8, 1, 0, "R4 restart zeroes count");
    bus_rd(4'hC, 2, 0, "R5 parked alarm");
    chk_irq("R8 irq parked alarm");

    // R3 divider value 0 means 65536
    bus_wr(4'h0, 32'h0004_0000);
    bus_rd(4'hC, 3, 0, "R7 clear after restart");
    while (e < 65534) idle(1);
    bus_rd(4'h8, 1, 0, "R3 P=0 before step");
    bus_rd(4'h8, 1, 0, "R3 P=0 after step");
    bus_rd(4'hC, 2, 0, "R6 step flag P=0");

    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule